// File: doc/BRIEF.md
# QPSK Carrier Modulator

This block turns a serial bit stream into a carrier-modulated sample stream. Each pair of bits forms one symbol. The first bit of the pair sets a signed in-phase gain and the second sets a signed quadrature gain. The in-phase gain scales a cosine carrier and the quadrature gain scales a sine carrier, and the block emits their sum as one signed sample for each clock-enable cycle. The carrier runs at a quarter of the sample rate, so the cosine and sine values are taken from a four-step cycle with no lookup table. Each symbol's gains stay fixed for 16 samples.

Bits come from one of two places, chosen by a static mode input. The first is an external valid/ready handshake that buffers one bit pair. The second is an internal 16-bit maximal-length pseudo-random generator. A strobe marks the first sample of every symbol. A pulse marks the final sample of every 128th symbol, which closes a 256-bit block. When no bit pair is ready at a symbol boundary, the block stalls: it produces no samples, and the carrier phase does not advance.

Top module: `qpsk_carrier_mod`

## Requirements
- R1: In external mode (`use_prbs`=0) a bit is accepted on a rising edge where `bit_valid` and `bit_ready` are both high. Of each accepted pair, the first bit drives the in-phase gain and the second drives the quadrature gain. `bit_ready` is high while fewer than two bits are buffered.
- R2: A bit value of 0 gives a gain of +AMP and a value of 1 gives -AMP (AMP defaults to 90). Every valid output sample is therefore +AMP or -AMP.
- R3: Each symbol's gains are held for exactly SPS (default 16) valid samples. `sym_start` is high together with the first of those samples and low on all the others.
- R4: Let n be the sample index inside the symbol. The output is gi*cos(pi*n/2) + gq*sin(pi*n/2). For n mod 4 = 0, 1, 2, 3 this gives +gi, +gq, -gi and -gq.
- R5: A sample is produced only for a cycle with `en` high. It appears on `samp` with `samp_valid` high on the cycle after that rising edge. While `samp_valid` is low, `samp`, `sym_start` and `block_done` are 0.
- R6: If no complete bit pair is available at a symbol boundary, cycles with `en` high produce no sample and do not advance the carrier phase. The symbol starts once a pair is available.
- R7: In generator mode (`use_prbs`=1) `bit_ready` is 0 and `bit_valid`/`bit_data` have no effect. The bits come from a 16-bit register seeded with 16'hACE1. Each step shifts the register left and inserts s[15]^s[13]^s[12]^s[10] at bit 0, and that inserted bit is the emitted bit. Each symbol takes two steps: the first emitted bit is the in-phase bit and the second is the quadrature bit.
- R8: `block_done` is high together with the final sample of every 128th symbol counted from reset, and is low at all other times.
- R9: During and directly after reset, `samp_valid`, `samp`, `sym_start` and `block_done` are 0. In external mode `bit_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Sample clock-enable |
| use_prbs | input | 1 | 1 selects the internal bit generator, 0 selects the external handshake (static) |
| bit_valid | input | 1 | External bit offered |
| bit_data | input | 1 | External bit value |
| bit_ready | output | 1 | Block can accept an external bit |
| samp_valid | output | 1 | `samp` carries a new sample |
| samp | output | AMP_W+1 | Signed modulated sample |
| sym_start | output | 1 | First sample of a symbol |
| block_done | output | 1 | Final sample of a 128-symbol block |

## Verification
Several properties are checked in every cycle:
- every valid sample has magnitude AMP;
- the half-cycle sample is the negative of the quarter-cycle-zero sample;
- gains change only when a pair is taken;
- a pair is never taken before it is complete;
- exactly SPS samples separate two symbol starts;
- the block pulse falls on a symbol's last carrier step.

Some behaviour can only be shown by the bench's scenarios. These cover the exact order of samples for every gain combination, and the bit order and generator sequence. They also cover stall behaviour and phase continuity under starved input, with `en` running steadily and gated, and the absolute 128-symbol position of the block pulse.

// File: rtl/qpsk_mod_pkg.sv
package qpsk_mod_pkg;

  localparam int LFSR_W = 16;

  // One step of the bit generator; the new bit enters at position 0.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Which carrier term a sample uses, by phase index mod 4.
  typedef enum logic [1:0] {
    PH_I_POS = 2'd0,
    PH_Q_POS = 2'd1,
    PH_I_NEG = 2'd2,
    PH_Q_NEG = 2'd3
  } carrier_phase_e;

endpackage

// File: rtl/qpsk_bit_source.sv
module qpsk_bit_source
  import qpsk_mod_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_prbs,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  input  logic pair_take,
  output logic pair_avail,
  output logic pair_i,
  output logic pair_q
);

  logic [1:0]        buf_cnt;
  logic              buf_i, buf_q;
  logic              accept;
  logic [LFSR_W-1:0] lfsr, step1, step2;

  assign bit_ready = !use_prbs && (buf_cnt != 2'd2);
  assign accept    = bit_valid && bit_ready;

  assign step1 = lfsr_step(lfsr);
  assign step2 = lfsr_step(step1);

  assign pair_avail = use_prbs ? 1'b1 : (buf_cnt == 2'd2);
  assign pair_i     = use_prbs ? step1[0] : buf_i;
  assign pair_q     = use_prbs ? step2[0] : buf_q;

  // External pair buffer: first accepted bit is I, second is Q.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_cnt <= 2'd0;
      buf_i   <= 1'b0;
      buf_q   <= 1'b0;
    end else if (pair_take && !use_prbs) begin
      buf_cnt <= 2'd0;
    end else if (accept) begin
      if (buf_cnt == 2'd0) buf_i <= bit_data;
      else                 buf_q <= bit_data;
      buf_cnt <= buf_cnt + 2'd1;
    end
  end

  // Generator advances two steps per consumed symbol.
  always_ff @(posedge clk) begin
    if (!rst_n)                    lfsr <= SEED;
    else if (pair_take && use_prbs) lfsr <= step2;
  end

  assert_buf_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    buf_cnt <= 2'd2);

  assert_take_needs_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_take |-> pair_avail);

  assert_lfsr_alive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

endmodule

// File: rtl/qpsk_symbol_timer.sv
module qpsk_symbol_timer #(
  parameter int SPS            = 16,
  parameter int SYMS_PER_BLOCK = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pair_avail,
  output logic       pair_take,
  output logic       step,
  output logic [1:0] phase,
  output logic       blk_last
);

  localparam int K_W = (SPS > 4) ? $clog2(SPS) : 2;
  localparam int S_W = (SYMS_PER_BLOCK > 1) ? $clog2(SYMS_PER_BLOCK) : 1;
  localparam int C_W = $clog2(SPS + 1);

  logic [K_W-1:0] k;
  logic [S_W-1:0] sym;
  logic           at_first, at_last, sym_last;

  assign at_first  = (k == '0);
  assign at_last   = (k == K_W'(SPS - 1));
  assign sym_last  = (sym == S_W'(SYMS_PER_BLOCK - 1));
  assign step      = en && (!at_first || pair_avail);
  assign pair_take = en && at_first && pair_avail;
  assign phase     = k[1:0];
  assign blk_last  = step && at_last && sym_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k   <= '0;
      sym <= '0;
    end else if (step) begin
      k <= at_last ? '0 : k + K_W'(1);
      if (at_last) sym <= sym_last ? '0 : sym + S_W'(1);
    end
  end

  // Checker: samples issued since the last pair was taken.
  logic [C_W-1:0] since_take;
  always_ff @(posedge clk) begin
    if (!rst_n)         since_take <= C_W'(SPS);
    else if (pair_take) since_take <= C_W'(1);
    else if (step)      since_take <= since_take + C_W'(1);
  end

  assert_hold_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_take |-> since_take == C_W'(SPS));

endmodule

// File: rtl/qpsk_carrier_mixer.sv
module qpsk_carrier_mixer
  import qpsk_mod_pkg::*;
#(
  parameter int AMP_W = 8,
  parameter int AMP   = 90
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic                    pair_take,
  input  logic                    pair_i,
  input  logic                    pair_q,
  input  logic [1:0]              phase,
  input  logic                    blk_last,
  output logic                    samp_valid,
  output logic signed [AMP_W:0]   samp,
  output logic                    sym_start,
  output logic                    block_done
);

  localparam int OUT_W = AMP_W + 1;

  function automatic logic [AMP_W-1:0] gain_of(input logic b);
    return b ? AMP_W'(-AMP) : AMP_W'(AMP);
  endfunction

  function automatic logic signed [OUT_W-1:0] carrier_term(
    input logic signed [AMP_W-1:0] gi,
    input logic signed [AMP_W-1:0] gq,
    input logic [1:0]              ph
  );
    logic signed [OUT_W-1:0] ei, eq;
    ei = gi;
    eq = gq;
    case (carrier_phase_e'(ph))
      PH_I_POS: return ei;
      PH_Q_POS: return eq;
      PH_I_NEG: return -ei;
      default:  return -eq;
    endcase
  endfunction

  logic [1:0]            lane_bit;
  logic [1:0][AMP_W-1:0] gain_hold, gain_cur;
  logic [1:0]            samp_phase;

  assign lane_bit = {pair_q, pair_i};

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign gain_cur[l] = pair_take ? gain_of(lane_bit[l]) : gain_hold[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_hold  <= '0;
      samp_valid <= 1'b0;
      samp       <= '0;
      sym_start  <= 1'b0;
      block_done <= 1'b0;
      samp_phase <= 2'd0;
    end else begin
      gain_hold  <= gain_cur;
      samp_valid <= step;
      samp       <= step ? carrier_term($signed(gain_cur[0]), $signed(gain_cur[1]), phase) : '0;
      sym_start  <= pair_take;
      block_done <= blk_last;
      samp_phase <= phase;
    end
  end

  // Checker: last sample seen at carrier phase 0.
  logic signed [OUT_W-1:0] p0_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)                                p0_seen <= '0;
    else if (samp_valid && samp_phase == 2'd0) p0_seen <= samp;
  end

  assert_amp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid |-> (samp == OUT_W'(AMP) || samp == OUT_W'(-AMP)));

  assert_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && samp_phase == 2'd2) |-> samp == -p0_seen);

  assert_gain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_take |=> $stable(gain_hold));

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |-> (samp == '0 && !sym_start && !block_done));

  assert_block_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> (samp_valid && samp_phase == 2'd3 && !sym_start));

endmodule

// File: rtl/qpsk_carrier_mod.sv
module qpsk_carrier_mod
  import qpsk_mod_pkg::*;
#(
  parameter int                AMP_W          = 8,
  parameter int                AMP            = 90,
  parameter int                SPS            = 16,
  parameter int                SYMS_PER_BLOCK = 128,
  parameter logic [LFSR_W-1:0] SEED           = 16'hACE1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  use_prbs,
  input  logic                  bit_valid,
  input  logic                  bit_data,
  output logic                  bit_ready,
  output logic                  samp_valid,
  output logic signed [AMP_W:0] samp,
  output logic                  sym_start,
  output logic                  block_done
);

  // Named internal events between the pieces.
  logic       pair_take, pair_avail, pair_i, pair_q;
  logic       step, blk_last;
  logic [1:0] phase;

  qpsk_bit_source #(.SEED(SEED)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .use_prbs   (use_prbs),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .bit_ready  (bit_ready),
    .pair_take  (pair_take),
    .pair_avail (pair_avail),
    .pair_i     (pair_i),
    .pair_q     (pair_q)
  );

  qpsk_symbol_timer #(.SPS(SPS), .SYMS_PER_BLOCK(SYMS_PER_BLOCK)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .pair_avail (pair_avail),
    .pair_take  (pair_take),
    .step       (step),
    .phase      (phase),
    .blk_last   (blk_last)
  );

  qpsk_carrier_mixer #(.AMP_W(AMP_W), .AMP(AMP)) u_mix (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .pair_take  (pair_take),
    .pair_i     (pair_i),
    .pair_q     (pair_q),
    .phase      (phase),
    .blk_last   (blk_last),
    .samp_valid (samp_valid),
    .samp       (samp),
    .sym_start  (sym_start),
    .block_done (block_done)
  );

endmodule

// File: tb/test_qpsk_carrier_mod.sv
module test_qpsk_carrier_mod;

  localparam int AMP = 90;
  localparam int SPS = 16;
  localparam int NSYM_MAX = 256;

  logic clk = 1'b0;
  logic rst_n, en, use_prbs, bit_valid, bit_data;
  logic bit_ready, samp_valid, sym_start, block_done;
  logic signed [8:0] samp;

  always #5 clk = ~clk;

  qpsk_carrier_mod i_qpsk_carrier_mod (
    .clk(clk), .rst_n(rst_n), .en(en), .use_prbs(use_prbs),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .samp_valid(samp_valid), .samp(samp), .sym_start(sym_start),
    .block_done(block_done)
  );

  int checks = 0;
  int failures = 0;
  bit exp_i [NSYM_MAX];
  bit exp_q [NSYM_MAX];
  int exp_n = 0;
  int samp_idx = 0;
  int bd_count = 0;
  bit mon_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  function automatic int model_sample(input bit bi, input bit bq, input int n);
    int gi, gq;
    gi = bi ? -AMP : AMP;
    gq = bq ? -AMP : AMP;
    case (n % 4)
      0: return gi;
      1: return gq;
      2: return -gi;
      default: return -gq;
    endcase
  endfunction

  // Monitor: samples 2 ns after each rising edge.
  always begin
    @(posedge clk);
    #2;
    if (mon_on) begin
      if (samp_valid) begin
        int sym, n;
        sym = samp_idx / SPS;
        n   = samp_idx % SPS;
        chk(en == 1'b1, "R5 sample follows an enabled cycle", int'(en), 1);
        if (sym >= exp_n) begin
          chk(1'b0, "R6 sample without a supplied symbol", samp_idx, exp_n * SPS);
        end else begin
          chk(int'(samp) == model_sample(exp_i[sym], exp_q[sym], n),
              "R2 R4 carrier sample", int'(samp), model_sample(exp_i[sym], exp_q[sym], n));
          chk(sym_start == (n == 0), "R3 symbol start strobe", int'(sym_start), int'(n == 0));
          chk(block_done == (n == SPS - 1 && (sym % 128) == 127),
              "R8 block done", int'(block_done), int'(n == SPS - 1 && (sym % 128) == 127));
        end
        if (block_done) bd_count++;
        samp_idx++;
      end else begin
        chk(samp == 0 && !sym_start && !block_done, "R5 idle outputs zero",
            int'(samp), 0);
      end
    end
  end

  task automatic send_bit(input bit b);
    bit_valid = 1'b1;
    bit_data  = b;
    while (!bit_ready) @(negedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_pair(input int s);
    send_bit(exp_i[s]);
    send_bit(exp_q[s]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    report();
    $finish;
  end

  initial begin
    bit hist [16 + 2 * NSYM_MAX];
    bit pat_i [8];
    bit pat_q [8];
    bit feed_done;
    logic [15:0] seed;
    pat_i = '{0, 0, 1, 1, 1, 0, 1, 0};
    pat_q = '{0, 1, 0, 1, 0, 0, 1, 1};

    rst_n = 1'b0; en = 1'b0; use_prbs = 1'b0; bit_valid = 1'b0; bit_data = 1'b0;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(samp_valid == 0 && samp == 0, "R9 reset outputs", int'(samp_valid), 0);
    chk(!sym_start && !block_done, "R9 reset strobes", int'(sym_start), 0);
    chk(bit_ready == 1'b1, "R9 ready in reset", int'(bit_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_ready == 1'b1, "R9 ready after reset", int'(bit_ready), 1);

    // External mode: every gain combination, bit order I then Q.
    for (int s = 0; s < 8; s++) begin
      exp_i[s] = pat_i[s];
      exp_q[s] = pat_q[s];
    end
    exp_n = 8;
    samp_idx = 0;
    mon_on = 1'b1;

    send_pair(0);
    chk(bit_ready == 1'b0, "R1 ready drops with pair buffered", int'(bit_ready), 0);
    repeat (5) @(negedge clk);
    chk(samp_idx == 0, "R5 no sample without enable", samp_idx, 0);
    en = 1'b1;
    for (int s = 1; s < 4; s++) send_pair(s);
    repeat (120) @(negedge clk);
    chk(samp_idx == 4 * SPS, "R6 starved boundary stalls", samp_idx, 4 * SPS);

    // Gated enable for the remaining symbols.
    feed_done = 1'b0;
    fork
      begin
        for (int s = 4; s < 8; s++) send_pair(s);
        feed_done = 1'b1;
      end
      begin
        while (!feed_done || samp_idx < 8 * SPS) begin
          @(negedge clk);
          en = ~en;
        end
      end
    join
    en = 1'b0;
    repeat (60) @(negedge clk);
    chk(samp_idx == 8 * SPS, "R6 sample count after gated run", samp_idx, 8 * SPS);

    // Generator mode.
    mon_on = 1'b0;
    rst_n = 1'b0;
    use_prbs = 1'b1;
    seed = 16'hACE1;
    for (int j = 0; j < 16; j++) hist[15 - j] = seed[j];
    for (int m = 16; m < 16 + 2 * NSYM_MAX; m++)
      hist[m] = hist[m-16] ^ hist[m-14] ^ hist[m-13] ^ hist[m-11];
    for (int s = 0; s < NSYM_MAX; s++) begin
      exp_i[s] = hist[16 + 2 * s];
      exp_q[s] = hist[17 + 2 * s];
    end
    exp_n = NSYM_MAX;
    repeat (3) @(negedge clk);
    samp_idx = 0;
    bd_count = 0;
    rst_n = 1'b1;
    mon_on = 1'b1;
    en = 1'b1;
    for (int c = 0; c < 130 * SPS + 20; c++) begin
      bit_valid = c[0];
      bit_data  = c[1];
      if (c % 200 == 0)
        chk(bit_ready == 1'b0, "R7 ready low in generator mode", int'(bit_ready), 0);
      @(negedge clk);
    end
    en = 1'b0;
    bit_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(samp_idx >= 130 * SPS, "R7 generator keeps supplying symbols", samp_idx, 130 * SPS);
    chk(bd_count == 1, "R8 one block pulse in 130 symbols", bd_count, 1);
    mon_on = 1'b0;

    report();
    $finish;
  end

endmodule